// File: doc/BRIEF.md
# Peripheral ROM Address Mapper

The mapper sits between a CPU bus and one unified ROM array. For CPU addresses in the window $C100..$CFFF it produces a 15-bit ROM array offset. The offset selects either the built-in ROM image in the low part of the array or the card ROM image $4000 higher. Two internal mode bits and one external enable decide which image is used.

The two mode bits are held in this block and are changed by bus writes to fixed addresses:

- The slot-wide bit redirects every page in $C1..$C7.
- The page-3 bit redirects only page $C3.

The external enable redirects the upper half of the window, $C800..$CFFF. Two status addresses report the mode bits on data bit 7. Writes into the ROM window are ignored. A hit flag tells the bus fabric that this block owns the current address.

Top module: `prmap_top`

## Requirements
- R1: For any address with no redirect in force, `rom_off_o` equals `{3'b000, addr_i[11:0]}`. So $C832 gives $0832 and $C232 gives $0232 when no mode is active.
- R2: When `exp_en_i` is 1, addresses $C800..$CFFF map with $4000 added: $C832 gives $4832 and $CFFF gives $4FFF.
- R3: When the slot-wide bit is 1, addresses $C100..$C7FF map with $4000 added: $C732 gives $4732 and $C100 gives $4100. $C000..$C0FF is never redirected.
- R4: When the page-3 bit is 1, addresses $C300..$C3FF map with $4000 added even if the slot-wide bit is 0. When both bits are 1, $4000 is added once only, so $C332 gives $4332. Other pages are not affected by the page-3 bit.
- R5: A write strobe at $C006 sets the slot-wide bit and one at $C007 clears it, whatever the value on `wdata_i`. The new value is visible from the first clock edge after the strobe.
- R6: A write strobe at $C00B sets the page-3 bit and one at $C00A clears it, whatever the value on `wdata_i`. The new value is visible from the first clock edge after the strobe.
- R7: With `rd_i` high, address $C015 returns $80 when the slot-wide bit is set and $00 when it is clear. Address $C017 does the same for the page-3 bit. In every other case `rdata_o` is $00.
- R8: Write strobes anywhere in $C100..$CFFF leave both mode bits unchanged.
- R9: Reset (`rst_ni` low) clears both mode bits.
- R10: `hit_o` is 1 exactly when `addr_i` is in $C100..$CFFF or is one of $C006, $C007, $C00A, $C00B, $C015, $C017.
- R11: `exp_en_i` has no effect on $C100..$C7FF. The two mode bits have no effect on $C800..$CFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 16 | CPU address |
| wdata_i | input | 8 | CPU write data (ignored by the switches) |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| exp_en_i | input | 1 | Upper-window card ROM enable |
| rom_off_o | output | 15 | ROM array offset |
| rdata_o | output | 8 | Status read data |
| hit_o | output | 1 | Address owned by this block |

## Verification
`rom_off_o`, `rdata_o` and `hit_o` are combinational, so the bench checks them one time unit after driving the inputs, in the same cycle. A mode-bit change is due at the first rising edge after its write strobe. The bench drives strobes on the falling edge and removes them on the next falling edge. It then reads the status addresses or mapped offsets, which makes every switch result due one edge after the write. Ignored writes are confirmed the same way, through status reads after the strobe.

// File: rtl/prmap_pkg.sv
package prmap_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned OFF_W  = 15;
  localparam int unsigned LOW_W  = 12;
  localparam logic [3:0] WIN_HI = 4'hC;
  localparam logic [ADDR_W-1:0] A_CX_SET = 16'hC006;
  localparam logic [ADDR_W-1:0] A_CX_CLR = 16'hC007;
  localparam logic [ADDR_W-1:0] A_C3_CLR = 16'hC00A;
  localparam logic [ADDR_W-1:0] A_C3_SET = 16'hC00B;
  localparam logic [ADDR_W-1:0] A_CX_ST  = 16'hC015;
  localparam logic [ADDR_W-1:0] A_C3_ST  = 16'hC017;

  typedef struct packed {
    logic in_win;
    logic cx_set;
    logic cx_clr;
    logic c3_set;
    logic c3_clr;
    logic cx_st;
    logic c3_st;
  } dec_t;

  typedef struct packed {
    logic cx;
    logic c3;
  } mode_t;
endpackage

// File: rtl/prmap_decode.sv
module prmap_decode
  import prmap_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);
  always_comb begin
    dec_o        = '0;
    dec_o.in_win = (addr_i[15:12] == WIN_HI) && (addr_i[11:8] != 4'h0);
    dec_o.cx_set = (addr_i == A_CX_SET);
    dec_o.cx_clr = (addr_i == A_CX_CLR);
    dec_o.c3_set = (addr_i == A_C3_SET);
    dec_o.c3_clr = (addr_i == A_C3_CLR);
    dec_o.cx_st  = (addr_i == A_CX_ST);
    dec_o.c3_st  = (addr_i == A_C3_ST);
  end
endmodule

// File: rtl/prmap_switches.sv
module prmap_switches
  import prmap_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_i,
  input  dec_t  dec_i,
  output mode_t mode_o
);
  mode_t mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
    end else if (wr_i) begin
      if (dec_i.cx_set)      mode_q.cx <= 1'b1;
      else if (dec_i.cx_clr) mode_q.cx <= 1'b0;
      if (dec_i.c3_set)      mode_q.c3 <= 1'b1;
      else if (dec_i.c3_clr) mode_q.c3 <= 1'b0;
    end
  end

  assign mode_o = mode_q;

  AST_CX_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && dec_i.cx_set |=> mode_o.cx); // R5
  AST_CX_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && dec_i.cx_clr |=> !mode_o.cx); // R5
  AST_C3_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && dec_i.c3_set |=> mode_o.c3); // R6
  AST_C3_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && dec_i.c3_clr |=> !mode_o.c3); // R6
  AST_WIN_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && dec_i.in_win |=> $stable(mode_o)); // R8
endmodule

// File: rtl/prmap_xlate.sv
module prmap_xlate
  import prmap_pkg::*;
#(
  parameter int unsigned REDIR_BIT = 14
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              in_win_i,
  input  logic              exp_en_i,
  input  mode_t             mode_i,
  output logic [OFF_W-1:0]  off_o
);
  logic [3:0] page;
  logic       upper, lower, pg3, redir;

  assign page  = addr_i[11:8];
  assign upper = page[3];
  assign lower = !page[3];
  assign pg3   = (page == 4'h3);
  // page-3 and slot-wide redirects OR together: the offset is added once
  assign redir = in_win_i &&
                 ((upper && exp_en_i) || (lower && mode_i.cx) || (pg3 && mode_i.c3));

  always_comb begin
    off_o            = '0;
    off_o[LOW_W-1:0] = addr_i[LOW_W-1:0];
    off_o[REDIR_BIT] = redir;
  end

  always_comb begin
    if (in_win_i && upper)
      AST_UPPER_EXP: assert (off_o[REDIR_BIT] == exp_en_i); // R11
  end
endmodule

// File: rtl/prmap_top.sv
module prmap_top
  import prmap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              exp_en_i,
  output logic [OFF_W-1:0]  rom_off_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              hit_o
);
  dec_t  dec;
  mode_t mode;
  logic  unused_wdata;

  assign unused_wdata = ^wdata_i;

  prmap_decode u_dec (.addr_i(addr_i), .dec_o(dec));

  prmap_switches u_sw (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (wr_i),
    .dec_i (dec),
    .mode_o(mode)
  );

  prmap_xlate #(.REDIR_BIT(OFF_W-1)) u_xl (
    .addr_i  (addr_i),
    .in_win_i(dec.in_win),
    .exp_en_i(exp_en_i),
    .mode_i  (mode),
    .off_o   (rom_off_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_i && dec.cx_st) rdata_o[DATA_W-1] = mode.cx;
    if (rd_i && dec.c3_st) rdata_o[DATA_W-1] = mode.c3;
  end

  assign hit_o = dec.in_win | dec.cx_set | dec.cx_clr | dec.c3_set |
                 dec.c3_clr | dec.cx_st  | dec.c3_st;

  AST_RDATA_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-2:0] == '0); // R7
  AST_RST_CLEAR: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> mode == '0); // R9
endmodule

// File: tb/prmap_top_tb_top.sv
module prmap_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        rd = 1'b0, wr = 1'b0, exp_en = 1'b0;
  logic [14:0] rom_off;
  logic [7:0]  rdata;
  logic        hit;
  int          n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  prmap_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .rd_i(rd), .wr_i(wr), .exp_en_i(exp_en),
    .rom_off_o(rom_off), .rdata_o(rdata), .hit_o(hit)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic offset_is(input string req, input logic [15:0] a, input logic [15:0] e);
    addr = a;
    #1;
    chk(req, {1'b0, rom_off}, e);
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic status_is(input string req, input logic [15:0] a, input logic [7:0] e);
    addr = a; rd = 1'b1;
    #1;
    chk(req, {8'h00, rdata}, {8'h00, e});
    rd = 1'b0;
  endtask

  task automatic t_reset;
    status_is("R9 cx", 16'hC015, 8'h00);
    status_is("R9 c3", 16'hC017, 8'h00);
  endtask

  task automatic t_base;
    offset_is("R1 C832", 16'hC832, 16'h0832);
    offset_is("R1 C232", 16'hC232, 16'h0232);
    offset_is("R1 C332", 16'hC332, 16'h0332);
  endtask

  task automatic t_exp;
    exp_en = 1'b1;
    offset_is("R2 C832", 16'hC832, 16'h4832);
    offset_is("R2 CFFF", 16'hCFFF, 16'h4FFF);
    offset_is("R11 C232 exp", 16'hC232, 16'h0232);
    offset_is("R11 C732 exp", 16'hC732, 16'h0732);
    exp_en = 1'b0;
  endtask

  task automatic t_slotcx;
    bus_wr(16'hC006, 8'h00);
    status_is("R5 set", 16'hC015, 8'h80);
    status_is("R7 c3 clear", 16'hC017, 8'h00);
    offset_is("R3 C732", 16'hC732, 16'h4732);
    offset_is("R3 C100", 16'hC100, 16'h4100);
    offset_is("R3 C0FF", 16'hC0FF, 16'h00FF);
    offset_is("R11 C832 cx", 16'hC832, 16'h0832);
    offset_is("R4 both once", 16'hC332, 16'h4332);
    bus_wr(16'hC007, 8'hFF);
    status_is("R5 clr", 16'hC015, 8'h00);
    offset_is("R5 clr map", 16'hC732, 16'h0732);
  endtask

  task automatic t_slot3;
    bus_wr(16'hC00B, 8'h5A);
    status_is("R6 set", 16'hC017, 8'h80);
    status_is("R7 cx clear", 16'hC015, 8'h00);
    offset_is("R4 C332", 16'hC332, 16'h4332);
    offset_is("R4 C3FF", 16'hC3FF, 16'h43FF);
    offset_is("R4 C232", 16'hC232, 16'h0232);
    offset_is("R4 C432", 16'hC432, 16'h0432);
    bus_wr(16'hC006, 8'h00);
    offset_is("R4 both", 16'hC332, 16'h4332);
    bus_wr(16'hC00A, 8'hA5);
    status_is("R6 clr", 16'hC017, 8'h00);
    offset_is("R3 C332 cx only", 16'hC332, 16'h4332);
    bus_wr(16'hC007, 8'h00);
  endtask

  task automatic t_window_write;
    bus_wr(16'hC006, 8'h00);
    bus_wr(16'hC00B, 8'h00);
    bus_wr(16'hC100, 8'h00);
    bus_wr(16'hC7FF, 8'hFF);
    bus_wr(16'hCFFF, 8'h00);
    status_is("R8 cx held", 16'hC015, 8'h80);
    status_is("R8 c3 held", 16'hC017, 8'h80);
    bus_wr(16'hC007, 8'h00);
    bus_wr(16'hC00A, 8'h00);
    bus_wr(16'hC300, 8'hFF);
    status_is("R8 cx still clear", 16'hC015, 8'h00);
    status_is("R8 c3 still clear", 16'hC017, 8'h00);
  endtask

  task automatic t_status_misc;
    bus_wr(16'hC006, 8'h00);
    addr = 16'hC015; rd = 1'b0; #1;
    chk("R7 no rd", {8'h00, rdata}, 16'h0000);
    status_is("R7 other addr", 16'hC016, 8'h00);
    bus_wr(16'hC007, 8'h00);
  endtask

  task automatic t_hit;
    logic [15:0] yes [8] = '{16'hC100, 16'hCFFF, 16'hC006, 16'hC007,
                            16'hC00A, 16'hC00B, 16'hC015, 16'hC017};
    logic [15:0] no  [5] = '{16'hC0FF, 16'hD000, 16'hC000, 16'hC016, 16'hBFFF};
    foreach (yes[i]) begin addr = yes[i]; #1; chk("R10 hit", {15'b0, hit}, 16'h1); end
    foreach (no[i])  begin addr = no[i];  #1; chk("R10 miss", {15'b0, hit}, 16'h0); end
  endtask

  task automatic t_reset_clears;
    bus_wr(16'hC006, 8'h00);
    bus_wr(16'hC00B, 8'h00);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    status_is("R9 cx after rst", 16'hC015, 8'h00);
    status_is("R9 c3 after rst", 16'hC017, 8'h00);
  endtask

  initial begin : watchdog
    #2000000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_base();
    t_exp();
    t_slotcx();
    t_slot3();
    t_window_write();
    t_status_misc();
    t_hit();
    t_reset_clears();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule